// File: doc/BRIEF.md
# Command block list processor

This block is the sequencing half of a command unit. Memory holds a chain of command blocks. The host points the unit at the first block and starts it. The unit then fetches each block over a plain request/acknowledge memory port and decodes its control bits. Opcodes that carry data are handed to an external hook, which acknowledges them. The unit writes a completion status back into the block, pulses interrupts, and then either follows the block's link to the next block, suspends or goes idle.

Each block occupies two 32-bit words at its byte address B:
- The word at B holds the status halfword in bits 15:0 and the command halfword in bits 31:16.
- The word at B+4 is the link, which is the offset of the next block.

Command bits:
- Bit 15 is end-of-list.
- Bit 14 is suspend.
- Bit 13 is interrupt-on-completion.
- Bit 4 is no-CRC, which the unit passes through unchanged.
- Bits 2:0 are the opcode.

The opcodes are 0 no-op, 1 address setup, 2 configure, 3 multicast list, 4 transmit, 5 load microcode, 6 dump and 7 diagnose.

The host drives a 2-bit command code for one cycle: 0 none, 1 start, 2 resume, 3 load base. The operand comes from a general pointer input. The unit state is 0 idle, 1 suspended or 2 active.

Top module: `cmd_list_walker`

## Requirements
- R1: After reset `cu_state` is 0 (idle), `mem_req`, `hook_valid`, `irq_cx` and `irq_cna` are low, and `cu_state` never takes the value 3.
- R2: Host code 3 loads the command base from `gen_ptr`. Host code 1 (start), given while idle or suspended, sets `cu_state` to 2 and loads the offset from `gen_ptr`. The first read is then at base + offset.
- R3: A block at byte address B = base + offset is read in two steps. First the word at B, whose bits 31:16 are the command and bits 15:0 the status. Then the word at B+4, whose low address bits replace the offset.
- R4: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until the cycle in which `mem_ack` is seen.
- R5: Completion writes the word at B with the command unchanged in bits 31:16 and the status OR 0xA000 (bits 15 and 13 set, other bits kept) in bits 15:0.
- R6: Opcodes 1 to 6 raise `hook_valid`, with `hook_op` set to the opcode and `hook_addr` set to B, after the link read and before the write-back. `hook_valid` is held until `hook_ack`. Opcodes 0 and 7 skip the hook.
- R7: `irq_cx` pulses for one cycle, the cycle after the write-back is acknowledged, when command bit 13 is set.
- R8: If command bit 15 is set, the write-back moves the unit to 0 (idle) and `irq_cna` pulses in the same cycle. This takes priority over bit 14.
- R9: If bit 14 is set and bit 15 is clear, the unit moves to 1 (suspended) and `irq_cna` pulses.
- R10: With bits 15 and 14 clear, the next block is fetched at base + link with no interrupt from `irq_cna`.
- R11: Host code 2 (resume), given while suspended or while idle, sets the state to 2. Fetching then continues at base + the current offset.
- R12: `mem_err` seen together with `mem_ack` ends the list. The state becomes 0, no further access is made, and no interrupt pulses.
- R13: Host codes are ignored while the state is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_cmd | input | 2 | 0 none, 1 start, 2 resume, 3 load base |
| gen_ptr | input | AW | Operand for start and load base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed (with ack) |
| mem_rdata | input | 32 | Read data (with ack) |
| hook_valid | output | 1 | Data-moving opcode pending |
| hook_op | output | 3 | Opcode of the pending block |
| hook_addr | output | AW | Address of the pending block |
| hook_ack | input | 1 | Hook finished |
| irq_cx | output | 1 | Completed-action interrupt pulse |
| irq_cna | output | 1 | Not-active interrupt pulse |
| cu_state | output | 2 | 0 idle, 1 suspended, 2 active |

## Verification
Several functions can land in the same cycle:
- The completed-action pulse and the not-active pulse can both come from one write-back.
- The end-of-list choice and the suspend choice can both apply to one block.

Table entries whose blocks carry the interrupt bit together with end-of-list and/or suspend provoke these. The bench counts cycles in which both pulses are high at once, and judges the final state against the end-of-list-over-suspend priority. A start issued while a list is still being walked checks that a host command cannot collide with the walk. The bench judges this from the addresses the memory model logs and from a decoy block that must stay untouched.

// File: rtl/cmd_list_walker.sv
module cmd_list_walker #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_cmd,
  input  logic [AW-1:0] gen_ptr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  output logic          hook_valid,
  output logic [2:0]    hook_op,
  output logic [AW-1:0] hook_addr,
  input  logic          hook_ack,
  output logic          irq_cx,
  output logic          irq_cna,
  output logic [1:0]    cu_state
);
  localparam logic [1:0] ST_IDLE = 2'd0, ST_SUSP = 2'd1, ST_ACT = 2'd2;
  localparam logic [AW-1:0] LINK_OFS = AW'(4);

  typedef enum logic [2:0] {PH_WAIT, PH_RD0, PH_RD1, PH_HOOK, PH_WR} ph_t;

  ph_t           ph;
  logic [1:0]    st;
  logic [AW-1:0] base, ofs, blk;
  logic [15:0]   stat, cmd;

  wire [AW-1:0] cur    = base + ofs;
  wire [2:0]    opc    = cmd[2:0];
  wire          hooked = (opc != 3'd0) && (opc != 3'd7);

  assign mem_req    = (ph == PH_RD0) || (ph == PH_RD1) || (ph == PH_WR);
  assign mem_we     = (ph == PH_WR);
  assign mem_addr   = (ph == PH_RD0) ? cur : (ph == PH_RD1) ? blk + LINK_OFS : blk;
  assign mem_wdata  = {cmd, stat | 16'hA000};
  assign hook_valid = (ph == PH_HOOK);
  assign hook_op    = opc;
  assign hook_addr  = blk;
  assign cu_state   = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_WAIT; st <= ST_IDLE;
      base <= '0; ofs <= '0; blk <= '0;
      stat <= '0; cmd <= '0;
      irq_cx <= 1'b0; irq_cna <= 1'b0;
    end else begin
      irq_cx  <= 1'b0;
      irq_cna <= 1'b0;
      case (ph)
        PH_WAIT:
          case (host_cmd)
            2'd1: begin st <= ST_ACT; ofs <= gen_ptr; ph <= PH_RD0; end
            2'd2: begin st <= ST_ACT; ph <= PH_RD0; end
            2'd3: base <= gen_ptr;
            default: ;
          endcase
        PH_RD0:
          if (mem_ack) begin
            if (mem_err) begin st <= ST_IDLE; ph <= PH_WAIT; end
            else begin
              stat <= mem_rdata[15:0];
              cmd  <= mem_rdata[31:16];
              blk  <= cur;
              ph   <= PH_RD1;
            end
          end
        PH_RD1:
          if (mem_ack) begin
            if (mem_err) begin st <= ST_IDLE; ph <= PH_WAIT; end
            else begin
              ofs <= mem_rdata[AW-1:0];
              ph  <= hooked ? PH_HOOK : PH_WR;
            end
          end
        PH_HOOK:
          if (hook_ack) ph <= PH_WR;
        PH_WR:
          if (mem_ack) begin
            if (mem_err) begin st <= ST_IDLE; ph <= PH_WAIT; end
            else begin
              irq_cx <= cmd[13];
              if (cmd[15]) begin
                st <= ST_IDLE; irq_cna <= 1'b1; ph <= PH_WAIT;
              end else if (cmd[14]) begin
                st <= ST_SUSP; irq_cna <= 1'b1; ph <= PH_WAIT;
              end else
                ph <= PH_RD0;
            end
          end
        default: ph <= PH_WAIT;
      endcase
    end
  end

  a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cu_state != 2'd3);

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r6_hook_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    hook_valid |-> cu_state == ST_ACT && !mem_req);

  a_r7_cx_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cx |-> $past(mem_we && mem_ack && !mem_err));

  a_r8_cna_not_active: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cna |-> cu_state != ST_ACT);

  a_r12_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> cu_state == ST_IDLE && !mem_req && !irq_cx && !irq_cna);
endmodule

// File: tb/sim_cmd_list_walker.sv
`timescale 1ns/1ps
module sim_cmd_list_walker;
  localparam int AW = 16;
  logic clk = 0, rst_n = 0;
  logic [1:0] host_cmd = 0;
  logic [AW-1:0] gen_ptr = 0;
  logic mem_req, mem_we, mem_ack = 0, mem_err = 0, hook_valid, hook_ack = 0, irq_cx, irq_cna;
  logic [AW-1:0] mem_addr, hook_addr;
  logic [31:0] mem_wdata, mem_rdata = 0;
  logic [2:0] hook_op;
  logic [1:0] cu_state;

  cmd_list_walker #(.AW(AW)) u0 (.*);

  always #2 clk = ~clk;

  logic [31:0] mem [0:255];
  logic [16:0] alog [0:63];
  int lp = 0, dly = 0, lat = 1, hdly = 0;
  logic [AW-1:0] err_addr = 16'hFFFF;
  int cx_cnt = 0, cna_cnt = 0, both_cnt = 0, hook_cnt = 0;
  logic [2:0] last_op = 0;
  logic [AW-1:0] last_haddr = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) begin
    mem_ack <= 0; mem_err <= 0; hook_ack <= 0;
    if (mem_req && !mem_ack) begin
      if (dly >= lat) begin
        dly <= 0; mem_ack <= 1;
        mem_rdata <= mem[mem_addr[9:2]];
        if (mem_addr == err_addr) mem_err <= 1;
        else if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        if (lp < 64) alog[lp] <= {mem_we, mem_addr};
        lp <= lp + 1;
      end else dly <= dly + 1;
    end
    if (hook_valid && !hook_ack) begin
      if (hdly >= 2) begin
        hdly <= 0; hook_ack <= 1; hook_cnt <= hook_cnt + 1;
        last_op <= hook_op; last_haddr <= hook_addr;
      end else hdly <= hdly + 1;
    end
  end

  always @(negedge clk) begin
    if (irq_cx) cx_cnt <= cx_cnt + 1;
    if (irq_cna) cna_cnt <= cna_cnt + 1;
    if (irq_cx && irq_cna) both_cnt <= both_cnt + 1;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host(logic [1:0] c, logic [AW-1:0] p);
    @(negedge clk); host_cmd = c; gen_ptr = p;
    @(negedge clk); host_cmd = 0;
  endtask

  task automatic settle();
    int n = 0;
    while (cu_state == 2'd2 && n < 1000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_counts();
    @(negedge clk);
    cx_cnt = 0; cna_cnt = 0; both_cnt = 0; hook_cnt = 0; lp = 0;
  endtask

  task automatic put_block(int addr, logic [15:0] c, logic [15:0] s, logic [31:0] link);
    mem[addr[9:2]] = {c, s};
    mem[addr[9:2] + 1] = link;
  endtask

  // {cmd, status, final state, cx, cna, hook}
  localparam logic [36:0] VEC [0:5] = '{
    {16'h8000, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b0},
    {16'hA004, 16'h1234, 2'd0, 1'b1, 1'b1, 1'b1},
    {16'h4001, 16'h0055, 2'd1, 1'b0, 1'b1, 1'b1},
    {16'hE007, 16'h0F00, 2'd0, 1'b1, 1'b1, 1'b0},
    {16'h6002, 16'h4000, 2'd1, 1'b1, 1'b1, 1'b1},
    {16'h8015, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1}
  };

  localparam int BASE = 'h100;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    check("R1 state after reset", cu_state, 0);
    check("R1 req after reset", {mem_req, hook_valid, irq_cx, irq_cna}, 0);
    rst_n = 1;
    host(2'd3, BASE);

    for (int i = 0; i < 6; i++) begin
      logic [36:0] v;
      v = VEC[i];
      lat = i % 3;
      put_block(BASE + 'h40, v[36:21], v[20:5], 32'h0);
      clear_counts();
      host(2'd1, 'h40);
      settle();
      check("R2 first read address", alog[0], {1'b0, 16'(BASE + 'h40)});
      check("R3 link read address", alog[1], {1'b0, 16'(BASE + 'h44)});
      check("R5 write-back", mem[(BASE + 'h40) >> 2], {v[36:21], v[20:5] | 16'hA000});
      check("R8 R9 final state", cu_state, v[4:3]);
      check("R7 cx pulses", cx_cnt, v[2]);
      check("R8 R9 cna pulses", cna_cnt, v[1]);
      check("R7 R8 same-cycle interrupts", both_cnt, v[2] & v[1]);
      check("R6 hook count", hook_cnt, v[0]);
      if (v[0]) begin
        check("R6 hook opcode", last_op, v[23:21]);
        check("R6 hook address", last_haddr, BASE + 'h40);
      end
    end

    // R10 chain of three
    put_block(BASE + 'h10, 16'h0000, 16'h0001, 32'h20);
    put_block(BASE + 'h20, 16'h0007, 16'h0002, 32'h30);
    put_block(BASE + 'h30, 16'h8000, 16'h0003, 32'h00);
    clear_counts(); lat = 0;
    host(2'd1, 'h10);
    settle();
    check("R10 access count", lp, 9);
    check("R10 second block read", alog[3], {1'b0, 16'(BASE + 'h20)});
    check("R10 third block read", alog[6], {1'b0, 16'(BASE + 'h30)});
    check("R5 chain write 1", alog[2], {1'b1, 16'(BASE + 'h10)});
    check("R10 cna only at end", cna_cnt, 1);
    check("R10 final written", mem[(BASE + 'h30) >> 2], 32'h8000A003);
    check("R6 opcode 0 and 7 no hook", hook_cnt, 0);

    // R11 resume from suspended, then from idle
    put_block(BASE + 'h50, 16'h4000, 16'h0000, 32'h60);
    put_block(BASE + 'h60, 16'h8000, 16'h0000, 32'h70);
    put_block(BASE + 'h70, 16'h8000, 16'h0011, 32'h00);
    clear_counts(); lat = 2;
    host(2'd1, 'h50);
    settle();
    check("R9 suspended", cu_state, 1);
    host(2'd2, 0);
    check("R11 active after resume", cu_state, 2);
    settle();
    check("R11 resumed block written", mem[(BASE + 'h60) >> 2], 32'h8000A000);
    check("R11 idle after list", cu_state, 0);
    host(2'd2, 0);
    check("R11 resume from idle active", cu_state, 2);
    settle();
    check("R11 resume from idle written", mem[(BASE + 'h70) >> 2], 32'h8000A011);

    // R12 error on link read
    put_block(BASE + 'h80, 16'hA000, 16'h0000, 32'h00);
    err_addr = BASE + 'h84;
    clear_counts(); lat = 1;
    host(2'd1, 'h80);
    settle();
    err_addr = 16'hFFFF;
    check("R12 idle after error", cu_state, 0);
    check("R12 no write", mem[(BASE + 'h80) >> 2], 32'hA0000000);
    check("R12 no interrupt", cx_cnt + cna_cnt, 0);
    check("R12 accesses stop", lp, 2);

    // R13 host commands ignored while active
    put_block(BASE + 'h90, 16'h0000, 16'h0000, 32'hA0);
    put_block(BASE + 'hA0, 16'h8000, 16'h0000, 32'h00);
    put_block(BASE + 'hC0, 16'h8000, 16'h0000, 32'h00);
    clear_counts(); lat = 2;
    host(2'd1, 'h90);
    host(2'd1, 'hC0);
    host(2'd3, 'h200);
    settle();
    check("R13 list completed", mem[(BASE + 'hA0) >> 2], 32'h8000A000);
    check("R13 decoy untouched", mem[(BASE + 'hC0) >> 2], 32'h80000000);

    // R2 load base then start
    put_block('h210, 16'h8000, 16'h0042, 32'h00);
    clear_counts();
    host(2'd3, 'h200);
    host(2'd1, 'h10);
    settle();
    check("R2 new base used", mem['h210 >> 2], 32'h8000A042);
    check("R1 state legal", cu_state != 2'd3, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule